// File: doc/BRIEF.md
# Shadowed Window Register Update Controller

This block keeps two copies of the configuration for a set of display windows. Software writes only the shadow copy. The display pipeline sees only the active copy. Each window has four 32-bit registers: a control word with the window enable in bit 0, a base address, a start position and an end position. The block does not interpret any field except the enable bit, which it also drives out as a dedicated per-window line.

Moving the shadow values into the active copy is an atomic, frame-aligned event. Software raises a protect flag, edits any number of window registers, lowers protect and then posts an update request. The request is sticky. At the first frame-boundary strobe that finds a request pending and protect low, every window's shadow registers are copied into the active registers together, and the request clears itself. A pipeline that fetches from the active copy therefore never sees a half-edited window set.

Top module: `shadowed_win_update`

## Requirements
- R1: After reset, every shadow and active register reads zero, all window enable outputs are low, protect is low and no update is pending; a frame strobe right after reset changes nothing.
- R2: A write with address bits [4:2] equal to a window number below NUM_WIN stores the 32-bit data in that window's shadow register chosen by bits [1:0] (0 control, 1 base address, 2 start position, 3 end position). The value reads back on rd_data the cycle after the write, and the active copy is unchanged.
- R3: The global control register is at address 5'h1C. On a write, bit 0 sets the protect level and a 1 in bit 1 posts an update request. A 0 in bit 1 does not cancel a pending request. A read returns protect in bit 0, pending in bit 1 and zero elsewhere.
- R4: A rising clock edge with frame_strobe high, a request pending and protect low copies all shadow registers of all windows into the active registers. The new values appear on act_rd_data the following cycle, and the pending flag clears.
- R5: While protect is set, a frame strobe transfers nothing and the pending request is kept.
- R6: A pending request with no frame strobe is held indefinitely. A frame strobe with no request pending transfers nothing, even when shadow and active differ.
- R7: win_en_o[w] equals bit 0 of window w's active control register. Clearing that bit in the shadow copy turns the window off only once a transfer takes place.
- R8: A request posted on the same edge as a frame strobe does not cause a transfer on that strobe. A request posted on the edge of a transfer remains pending afterwards. A shadow write on the transfer edge is not part of that transfer: the active copy gets the value the shadow held before the write.
- R9: Writes to unmapped addresses (window numbers from NUM_WIN up to 6, or fields 1 to 3 of slot 7) change no register. Reads of those addresses return zero on both read ports, and the active read port returns zero for 5'h1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (5) | Write address: window slot in [4:2], field in [1:0] |
| wr_data_i | input | DATA_W (32) | Write data |
| rd_addr_i | input | ADDR_W (5) | Shadow / control read address |
| rd_data_o | output | DATA_W (32) | Shadow register or global control read value |
| act_rd_addr_i | input | ADDR_W (5) | Active register read address |
| act_rd_data_o | output | DATA_W (32) | Active register read value |
| frame_strobe_i | input | 1 | One-cycle frame boundary pulse |
| win_en_o | output | NUM_WIN (5) | Active enable bit of each window |

## Verification
A wrong shadow value shows on rd_data one cycle after the write. A wrong copy only reaches act_rd_data and win_en_o after the next transfer, so each check that expects a transfer reads both ports on the cycle right after the strobe edge. A lost or stuck pending flag shows on bit 1 of the control read before any strobe arrives. If the flag is missing, the active copy fails to follow the shadow on the next strobe; if it is stuck, the active copy follows the shadow on a strobe that should have done nothing. Same-edge collisions between a request, a strobe and a shadow write are driven on purpose, because an ordering slip there changes an active value by exactly one frame.

// File: rtl/swu_pkg.sv
package swu_pkg;
    localparam int FLD_W   = 2;
    localparam int FLD_CNT = 1 << FLD_W;

    typedef enum logic [FLD_W-1:0] {
        FLD_CTRL  = 2'd0,
        FLD_BASE  = 2'd1,
        FLD_START = 2'd2,
        FLD_END   = 2'd3
    } fld_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int GLB_PROT_BIT = 0;
    localparam int GLB_REQ_BIT  = 1;
endpackage

// File: rtl/swu_addr_dec.sv
module swu_addr_dec
    import swu_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int IDX_W   = 3
) (
    input  logic [IDX_W+FLD_W-1:0] addr_i,
    output logic [NUM_WIN-1:0]     win_hit_o,
    output logic                   glb_hit_o,
    output logic [FLD_W-1:0]       fld_o
);
    logic [IDX_W-1:0] slot;

    assign slot  = addr_i[IDX_W+FLD_W-1:FLD_W];
    assign fld_o = addr_i[FLD_W-1:0];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_hit
        assign win_hit_o[w] = (slot == IDX_W'(w));
    end

    assign glb_hit_o = (slot == {IDX_W{1'b1}}) && (fld_o == FLD_CTRL);
endmodule

// File: rtl/swu_update_ctrl.sv
module swu_update_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic glb_wr_i,
    input  logic prot_wr_i,
    input  logic req_wr_i,
    input  logic frame_strobe_i,
    output logic protect_o,
    output logic pending_o,
    output logic commit_o
);
    typedef struct packed {
        logic prot;
        logic pend;
    } ctl_t;

    ctl_t d, q;

    assign commit_o  = frame_strobe_i && q.pend && !q.prot;
    assign protect_o = q.prot;
    assign pending_o = q.pend;

    always_comb begin
        d = q;
        if (commit_o)
            d.pend = 1'b0;
        if (glb_wr_i) begin
            d.prot = prot_wr_i;
            if (req_wr_i)
                d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // R6: a request survives every cycle without a frame strobe
    assert_pending_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.pend && !frame_strobe_i) |=> q.pend);

    // R5: protect keeps the request alive across strobes
    assert_protect_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.pend && q.prot) |=> q.pend);

    // R4: a transfer consumes the request unless a new one arrives on that edge
    assert_pending_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_o && !(glb_wr_i && req_wr_i)) |=> !q.pend);
endmodule

// File: rtl/swu_window_bank.sv
module swu_window_bank
    import swu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_en_i,
    input  logic [FLD_W-1:0]               wr_fld_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    input  logic                           commit_i,
    output logic [FLD_CNT-1:0][DATA_W-1:0] shd_o,
    output logic [FLD_CNT-1:0][DATA_W-1:0] act_o
);
    typedef struct packed {
        logic [FLD_CNT-1:0][DATA_W-1:0] shd;
        logic [FLD_CNT-1:0][DATA_W-1:0] act;
    } bank_t;

    bank_t d, q;

    always_comb begin
        d = q;
        if (commit_i)
            d.act = q.shd;
        if (wr_en_i)
            d.shd[wr_fld_i] = wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign shd_o = q.shd;
    assign act_o = q.act;

    // R4: active copy only moves on a transfer
    assert_active_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !commit_i |=> $stable(q.act));

    // R8: a transfer takes the shadow as it stood before the edge
    assert_active_copy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_i |=> (q.act == $past(q.shd)));

    // R2: shadow write lands in the addressed field
    assert_shadow_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (q.shd[$past(wr_fld_i)] == $past(wr_data_i)));
endmodule

// File: rtl/shadowed_win_update.sv
module shadowed_win_update
    import swu_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_WIN + 1),
    localparam int ADDR_W = IDX_W + FLD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [ADDR_W-1:0] act_rd_addr_i,
    output logic [DATA_W-1:0] act_rd_data_o,
    input  logic              frame_strobe_i,
    output logic [NUM_WIN-1:0] win_en_o
);
    logic [NUM_WIN-1:0] wr_hit, rd_hit, ard_hit;
    logic               wr_glb, rd_glb, ard_glb;
    logic [FLD_W-1:0]   wr_fld, rd_fld, ard_fld;
    logic               protect, pending, commit;

    logic [FLD_CNT-1:0][DATA_W-1:0] shd_all [NUM_WIN];
    logic [FLD_CNT-1:0][DATA_W-1:0] act_all [NUM_WIN];

    swu_addr_dec #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) i_wr_dec (
        .addr_i(wr_addr_i), .win_hit_o(wr_hit), .glb_hit_o(wr_glb), .fld_o(wr_fld));
    swu_addr_dec #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) i_rd_dec (
        .addr_i(rd_addr_i), .win_hit_o(rd_hit), .glb_hit_o(rd_glb), .fld_o(rd_fld));
    swu_addr_dec #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) i_ard_dec (
        .addr_i(act_rd_addr_i), .win_hit_o(ard_hit), .glb_hit_o(ard_glb), .fld_o(ard_fld));

    swu_update_ctrl i_ctrl (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .glb_wr_i       (wr_en_i && wr_glb),
        .prot_wr_i      (wr_data_i[GLB_PROT_BIT]),
        .req_wr_i       (wr_data_i[GLB_REQ_BIT]),
        .frame_strobe_i (frame_strobe_i),
        .protect_o      (protect),
        .pending_o      (pending),
        .commit_o       (commit)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        swu_window_bank #(.DATA_W(DATA_W)) i_bank (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_en_i   (wr_en_i && wr_hit[w]),
            .wr_fld_i  (wr_fld),
            .wr_data_i (wr_data_i),
            .commit_i  (commit),
            .shd_o     (shd_all[w]),
            .act_o     (act_all[w])
        );
        assign win_en_o[w] = act_all[w][FLD_CTRL][CTRL_EN_BIT];
    end

    always_comb begin
        rd_data_o     = '0;
        act_rd_data_o = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (rd_hit[w])  rd_data_o     |= shd_all[w][rd_fld];
            if (ard_hit[w]) act_rd_data_o |= act_all[w][ard_fld];
        end
        if (rd_glb) begin
            rd_data_o[GLB_PROT_BIT] = protect;
            rd_data_o[GLB_REQ_BIT]  = pending;
        end
    end

    // R7: enables move only on the edge of a frame strobe
    assert_enable_on_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(win_en_o) |-> $past(frame_strobe_i));

    // R9: the active port never reports the control register
    assert_act_glb_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ard_glb |-> (act_rd_data_o == '0));
endmodule

// File: tb/test_shadowed_win_update.sv
module test_shadowed_win_update;
    localparam int NUM_WIN = 5;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam logic [4:0] GLB = 5'h1C;

    // op: 0 write, 1 strobe, 2 write and strobe together, 3 idle
    // fields: op, addr, data, check addr, expected shadow, expected active, requirement
    localparam int NV = 25;
    localparam logic [111:0] VEC [NV] = '{
        {2'd0, 5'h01, 32'h1000_0000, 5'h01, 32'h1000_0000, 32'h0,         4'd2}, // R2
        {2'd0, 5'h00, 32'h0000_0003, 5'h00, 32'h0000_0003, 32'h0,         4'd2}, // R2
        {2'd1, 5'h00, 32'h0,         5'h00, 32'h0000_0003, 32'h0,         4'd6}, // R6 no request
        {2'd0, GLB,   32'h0000_0002, GLB,   32'h0000_0002, 32'h0,         4'd3}, // R3 request
        {2'd0, GLB,   32'h0000_0001, GLB,   32'h0000_0003, 32'h0,         4'd3}, // R3 protect, request kept
        {2'd1, 5'h00, 32'h0,         5'h00, 32'h0000_0003, 32'h0,         4'd5}, // R5 blocked
        {2'd0, GLB,   32'h0000_0000, GLB,   32'h0000_0002, 32'h0,         4'd6}, // R6 still pending
        {2'd1, 5'h00, 32'h0,         5'h00, 32'h0000_0003, 32'h0000_0003, 4'd4}, // R4 transfer
        {2'd3, 5'h00, 32'h0,         5'h01, 32'h1000_0000, 32'h1000_0000, 4'd4}, // R4
        {2'd3, 5'h00, 32'h0,         GLB,   32'h0,         32'h0,         4'd4}, // R4 pending cleared
        {2'd0, 5'h13, 32'hABCD_0123, 5'h13, 32'hABCD_0123, 32'h0,         4'd2}, // R2
        {2'd0, 5'h14, 32'hFFFF_FFFF, 5'h14, 32'h0,         32'h0,         4'd9}, // R9
        {2'd0, 5'h1D, 32'hFFFF_FFFF, 5'h1D, 32'h0,         32'h0,         4'd9}, // R9
        {2'd3, 5'h00, 32'h0,         GLB,   32'h0,         32'h0,         4'd9}, // R9 control untouched
        {2'd0, GLB,   32'h0000_0002, GLB,   32'h0000_0002, 32'h0,         4'd3}, // R3
        {2'd2, 5'h13, 32'h5555_AAAA, 5'h13, 32'h5555_AAAA, 32'hABCD_0123, 4'd8}, // R8 write on transfer edge
        {2'd3, 5'h00, 32'h0,         GLB,   32'h0,         32'h0,         4'd4}, // R4
        {2'd2, GLB,   32'h0000_0002, 5'h13, 32'h5555_AAAA, 32'hABCD_0123, 4'd8}, // R8 request with strobe
        {2'd3, 5'h00, 32'h0,         GLB,   32'h0000_0002, 32'h0,         4'd8}, // R8 now pending
        {2'd0, 5'h00, 32'h0000_0000, 5'h00, 32'h0,         32'h0000_0003, 4'd7}, // R7
        {2'd1, 5'h00, 32'h0,         5'h00, 32'h0,         32'h0,         4'd7}, // R7 disabled
        {2'd3, 5'h00, 32'h0,         5'h13, 32'h5555_AAAA, 32'h5555_AAAA, 4'd4}, // R4
        {2'd0, GLB,   32'h0000_0002, GLB,   32'h0000_0002, 32'h0,         4'd3}, // R3
        {2'd2, GLB,   32'h0000_0002, GLB,   32'h0000_0002, 32'h0,         4'd8}, // R8 re-request kept
        {2'd1, 5'h00, 32'h0,         GLB,   32'h0,         32'h0,         4'd4}  // R4
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] act_rd_addr = '0;
    logic [DATA_W-1:0] act_rd_data;
    logic              frame_strobe = 1'b0;
    logic [NUM_WIN-1:0] win_en;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    shadowed_win_update i_shadowed_win_update (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .act_rd_addr_i(act_rd_addr), .act_rd_data_o(act_rd_data),
        .frame_strobe_i(frame_strobe), .win_en_o(win_en));

    task automatic check(input int req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [4:0] addr,
                        input logic [31:0] data, input logic [4:0] chk);
        @(negedge clk);
        wr_en        = (op == 2'd0) || (op == 2'd2);
        frame_strobe = (op == 2'd1) || (op == 2'd2);
        wr_addr      = addr;
        wr_data      = data;
        @(negedge clk);
        wr_en        = 1'b0;
        frame_strobe = 1'b0;
        rd_addr      = chk;
        act_rd_addr  = chk;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        rd_addr = GLB; act_rd_addr = 5'h00; #1;
        check(1, "control after reset", rd_data, 32'h0);
        check(1, "active after reset", act_rd_data, 32'h0);
        check(1, "enables after reset", 32'(win_en), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][111:110], VEC[i][109:105], VEC[i][104:73], VEC[i][72:68]);
            check(int'(VEC[i][3:0]), $sformatf("vector %0d shadow", i), rd_data, VEC[i][67:36]);
            check(int'(VEC[i][3:0]), $sformatf("vector %0d active", i), act_rd_data, VEC[i][35:4]);
        end

        // R7: enable lines follow the active control bits of windows 2 and 4
        step(2'd0, 5'h08, 32'h1, 5'h08);
        step(2'd0, 5'h10, 32'h1, 5'h10);
        check(7, "enables before transfer", 32'(win_en), 32'h0);
        step(2'd0, GLB, 32'h2, GLB);
        step(2'd1, 5'h00, 32'h0, 5'h08);
        check(7, "enables after transfer", 32'(win_en), 32'h14);

        // R1: reset drops a pending request
        step(2'd0, GLB, 32'h3, GLB);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_addr = 5'h08; act_rd_addr = 5'h08; #1;
        check(1, "shadow after reset", rd_data, 32'h0);
        check(1, "enables after reset", 32'(win_en), 32'h0);
        step(2'd0, 5'h08, 32'h1, 5'h08);
        step(2'd1, 5'h00, 32'h0, 5'h08);
        check(1, "no transfer after reset", act_rd_data, 32'h0);
        rd_addr = GLB; #1;
        check(1, "control after reset", rd_data, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule